// File: doc/BRIEF.md
# Search Triplet Accelerator for a Single-Wire Bus Master

This block sits between a host byte port and the bit-slot engine of a single-wire bus master. It speeds up device enumeration. In search mode, one host byte drives four search steps. The low nibble of that byte gives the preferred branch for each of four ID bits.

For every ID bit the block runs three slots:
- a read of the ID bit;
- a read of its complement;
- a write of the chosen branch bit, which deselects every device that disagrees.

The block then hands back one byte:
- the high nibble holds the four bits it wrote;
- the low nibble holds a flag for each bit where devices disagreed.

Sixteen such exchanges walk a full 64-bit ID. With search mode off, a started byte is a plain 8-slot transfer. Each data bit is written LSB first, and the line value sampled in each slot is returned.

Each slot is a request/acknowledge exchange with the bit-slot engine. The block raises a request carrying the bit to put on the wire. It holds the request until the engine acknowledges with the sampled bit. Bus reset, the search command and the tracking of the last branch point stay with the host.

Top module: `srch_accel`

## Requirements
- R1: After reset `busy`, `slotReq`, `doneValid` and `noDevErr` are 0.
- R2: `start` is taken only while `busy` is 0. A `start` pulse during an exchange has no effect on its slots, its result or the number of completions.
- R3: Once raised, `slotReq` stays high with `slotBit` unchanged until a cycle with `slotAck` high. `slotRdBit` is taken in that acknowledge cycle, and the engine may stall any number of cycles first.
- R4: With search mode off at start, the exchange runs 8 slots. Slot i writes `hostData[i]` (i = 0 first), and bit i of `doneData` is the bit sampled in slot i.
- R5: With search mode on at start, the exchange runs 12 slots: for ID bit i = 0,1,2,3 in order, two read slots with `slotBit` = 1, then one write slot.
- R6: Search mode, ID bit i, reads differ: the write slot sends the first read value, `doneData[4+i]` equals it and `doneData[i]` is 0.
- R7: Search mode, both reads 0: the write slot sends `hostData[i]`, `doneData[4+i]` equals it, and `doneData[i]` is 1. Bits 7..4 of `hostData` are ignored.
- R8: Search mode, both reads 1 (no device): the write slot sends 1, and `doneData[4+i]` and `doneData[i]` are 1. `noDevErr` is 1 with the completion pulse.
- R9: The result appears on `doneData` during a single-cycle `doneValid` pulse, one cycle after the last acknowledge. `noDevErr` is 0 whenever `doneValid` is 0.
- R10: The mode is sampled from `accelEn` in the `start` cycle. Changing `accelEn` during an exchange does not change that exchange.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| accelEn | input | 1 | Search mode select, sampled at start |
| start | input | 1 | Begin an exchange (taken when idle) |
| hostData | input | 8 | Byte to send, or direction nibble in search mode |
| busy | output | 1 | Exchange in progress |
| slotReq | output | 1 | Bit-slot request to the bus engine |
| slotBit | output | 1 | Bit to drive in the requested slot (1 for a read slot) |
| slotAck | input | 1 | Slot finished, sampled bit valid |
| slotRdBit | input | 1 | Line value sampled in the slot |
| doneValid | output | 1 | One-cycle completion pulse |
| doneData | output | 8 | Result byte: received byte, or {written bits, discrepancy flags} |
| noDevErr | output | 1 | No device answered some search bit (with doneValid) |

## Verification
Some properties hold on every cycle, and the embedded assertions check them there:
- the request holds steady, with a constant bit, until it is acknowledged;
- the completion pulse lasts one cycle;
- an exchange starts only from a `start`;
- a no-device error comes with a bit that is both written and flagged.

Other behaviour only the scenarios can show, using a slot responder with variable stall:
- the branch choice for each read pair;
- the LSB-first slot order;
- the exact written bit sequence;
- ignoring a second `start`;
- sampling the mode once per exchange.

// File: rtl/srch_pkg.sv
package srch_pkg;
  localparam int SEARCH_BITS = 4;
  localparam int XFER_BITS   = 2 * SEARCH_BITS;
  localparam int IDX_W       = $clog2(XFER_BITS);
  localparam int SIDX_W      = $clog2(SEARCH_BITS);
  localparam int PH_W        = 2;
  localparam logic [PH_W-1:0] PH_READ0 = 2'd0;
  localparam logic [PH_W-1:0] PH_READ1 = 2'd1;
  localparam logic [PH_W-1:0] PH_WRITE = 2'd2;

  typedef struct packed {
    logic             load;
    logic             capFirst;
    logic             capSecond;
    logic             capNormal;
    logic             accel;
    logic [IDX_W-1:0] bitIdx;
    logic [PH_W-1:0]  phase;
  } ctrlStrobe_t;
endpackage

// File: rtl/srch_ctrl.sv
module srch_ctrl
  import srch_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        accelEn,
  input  logic        slotAck,
  output logic        busy,
  output logic        slotReq,
  output logic        doneValid,
  output ctrlStrobe_t strobe
);
  typedef enum logic [1:0] {S_IDLE, S_SLOT, S_DONE} state_t;

  state_t           state;
  logic             accelR;
  logic [IDX_W-1:0] bitIdx;
  logic [PH_W-1:0]  phase;
  logic [IDX_W-1:0] lastBit;
  logic [PH_W-1:0]  lastPhase;
  logic             slotDone;

  assign lastBit   = accelR ? IDX_W'(SEARCH_BITS - 1) : IDX_W'(XFER_BITS - 1);
  assign lastPhase = accelR ? PH_WRITE : PH_READ0;
  assign slotDone  = (state == S_SLOT) && slotAck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      accelR <= 1'b0;
      bitIdx <= '0;
      phase  <= PH_READ0;
    end else begin
      unique case (state)
        S_IDLE: if (start) begin
          accelR <= accelEn;
          bitIdx <= '0;
          phase  <= PH_READ0;
          state  <= S_SLOT;
        end
        S_SLOT: if (slotAck) begin
          if (phase == lastPhase) begin
            phase <= PH_READ0;
            if (bitIdx == lastBit) state <= S_DONE;
            else bitIdx <= bitIdx + 1'b1;
          end else begin
            phase <= phase + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    busy      = (state != S_IDLE);
    slotReq   = (state == S_SLOT);
    doneValid = (state == S_DONE);
    strobe.load      = (state == S_IDLE) && start;
    strobe.capFirst  = slotDone && accelR && (phase == PH_READ0);
    strobe.capSecond = slotDone && accelR && (phase == PH_READ1);
    strobe.capNormal = slotDone && !accelR;
    strobe.accel     = accelR;
    strobe.bitIdx    = bitIdx;
    strobe.phase     = phase;
  end

  // R3: a pending request is not withdrawn before its acknowledge
  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    slotReq && !slotAck |=> slotReq);

  // R9: completion is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    doneValid |=> !doneValid);

  // R2: an exchange begins only from an accepted start
  p_busy_from_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

// File: rtl/srch_datapath.sv
module srch_datapath
  import srch_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  ctrlStrobe_t          strobe,
  input  logic [XFER_BITS-1:0] hostData,
  input  logic                 slotReq,
  input  logic                 slotAck,
  input  logic                 slotRdBit,
  input  logic                 doneValid,
  output logic                 slotBit,
  output logic [XFER_BITS-1:0] doneData,
  output logic                 noDevErr
);
  logic [XFER_BITS-1:0]   dirR;
  logic [XFER_BITS-1:0]   normR;
  logic [SEARCH_BITS-1:0] sentR;
  logic [SEARCH_BITS-1:0] discR;
  logic                   firstR;
  logic                   errR;
  logic [SIDX_W-1:0]      sIdx;

  assign sIdx = strobe.bitIdx[SIDX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dirR   <= '0;
      normR  <= '0;
      sentR  <= '0;
      discR  <= '0;
      firstR <= 1'b0;
      errR   <= 1'b0;
    end else if (strobe.load) begin
      dirR   <= hostData;
      normR  <= '0;
      sentR  <= '0;
      discR  <= '0;
      firstR <= 1'b0;
      errR   <= 1'b0;
    end else begin
      if (strobe.capFirst) firstR <= slotRdBit;
      if (strobe.capNormal) normR[strobe.bitIdx] <= slotRdBit;
      if (strobe.capSecond) begin
        unique case ({firstR, slotRdBit})
          2'b00: begin
            sentR[sIdx] <= dirR[sIdx];
            discR[sIdx] <= 1'b1;
          end
          2'b11: begin
            sentR[sIdx] <= 1'b1;
            discR[sIdx] <= 1'b1;
            errR        <= 1'b1;
          end
          default: begin
            sentR[sIdx] <= firstR;
            discR[sIdx] <= 1'b0;
          end
        endcase
      end
    end
  end

  always_comb begin
    if (!strobe.accel)                 slotBit = dirR[strobe.bitIdx];
    else if (strobe.phase == PH_WRITE) slotBit = sentR[sIdx];
    else                               slotBit = 1'b1;
  end

  assign doneData = strobe.accel ? {sentR, discR} : normR;
  assign noDevErr = doneValid && errR;

  // R3: the bit offered in a slot does not change while it waits
  p_bit_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    slotReq && !slotAck |=> $stable(slotBit));

  // R8: a no-device error implies a bit both written as 1 and flagged
  p_err_flagged_r8: assert property (@(posedge clk) disable iff (!rst_n)
    noDevErr |-> ((doneData[XFER_BITS-1:SEARCH_BITS] & doneData[SEARCH_BITS-1:0]) != '0));

  // R9: the error output never appears outside a completion
  p_err_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !doneValid |-> !noDevErr);
endmodule

// File: rtl/srch_accel.sv
module srch_accel
  import srch_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 accelEn,
  input  logic                 start,
  input  logic [XFER_BITS-1:0] hostData,
  output logic                 busy,
  output logic                 slotReq,
  output logic                 slotBit,
  input  logic                 slotAck,
  input  logic                 slotRdBit,
  output logic                 doneValid,
  output logic [XFER_BITS-1:0] doneData,
  output logic                 noDevErr
);
  ctrlStrobe_t strobe;

  srch_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .accelEn   (accelEn),
    .slotAck   (slotAck),
    .busy      (busy),
    .slotReq   (slotReq),
    .doneValid (doneValid),
    .strobe    (strobe)
  );

  srch_datapath u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .hostData  (hostData),
    .slotReq   (slotReq),
    .slotAck   (slotAck),
    .slotRdBit (slotRdBit),
    .doneValid (doneValid),
    .slotBit   (slotBit),
    .doneData  (doneData),
    .noDevErr  (noDevErr)
  );
endmodule

// File: tb/srch_accel_tb.sv
module srch_accel_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       accelEn = 1'b0;
  logic       start = 1'b0;
  logic [7:0] hostData = 8'h00;
  logic       busy, slotReq, slotBit, doneValid, noDevErr;
  logic       slotAck = 1'b0;
  logic       slotRdBit = 1'b0;
  logic [7:0] doneData;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  int doneCnt = 0;

  // slot responder state
  logic [15:0] respVec = '0;
  logic [15:0] wrVec   = '0;
  int respIdx = 0;
  int wrCnt   = 0;
  int respLat = 1;
  int waitCnt = 0;

  logic [8:0] expQ[$];   // {err, data}

  always #4 clk = ~clk;    // 125 MHz

  srch_accel u_dut (
    .clk(clk), .rst_n(rst_n), .accelEn(accelEn), .start(start),
    .hostData(hostData), .busy(busy), .slotReq(slotReq), .slotBit(slotBit),
    .slotAck(slotAck), .slotRdBit(slotRdBit), .doneValid(doneValid),
    .doneData(doneData), .noDevErr(noDevErr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bit-slot engine model: stalls respLat cycles, acks for one cycle
  always @(negedge clk) begin
    if (slotAck) begin
      slotAck <= 1'b0;
    end else if (slotReq) begin
      if (waitCnt >= respLat) begin
        waitCnt   <= 0;
        slotAck   <= 1'b1;
        slotRdBit <= respVec[respIdx];
        respIdx   <= respIdx + 1;
        wrVec[wrCnt] <= slotBit;
        wrCnt     <= wrCnt + 1;
      end else begin
        waitCnt <= waitCnt + 1;
      end
    end
  end

  // monitor: pops expected items as completions appear
  always @(negedge clk) begin
    if (rst_n && doneValid) begin
      logic [8:0] e;
      doneCnt++;
      if (expQ.size() == 0) begin
        check(1'b0, "R2 unexpected completion", doneData, 0);
      end else begin
        e = expQ.pop_front();
        check(doneData == e[7:0], "R4/R6/R7/R9 result byte", doneData, e[7:0]);
        check(noDevErr == e[8], "R8 noDevErr", noDevErr, e[8]);
      end
    end else if (rst_n) begin
      if (noDevErr) check(1'b0, "R9 noDevErr without done", 1, 0);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  function automatic void model(input bit acc, input logic [7:0] dir, input logic [7:0] rd,
                                output logic [7:0] res, output bit err,
                                output logic [15:0] wr, output logic [15:0] resp,
                                output int nSlots);
    res = '0; err = 0; wr = '0; resp = '0;
    if (!acc) begin
      res = rd; wr[7:0] = dir; resp[7:0] = rd; nSlots = 8;
    end else begin
      nSlots = 12;
      for (int i = 0; i < 4; i++) begin
        logic a, b, s, d;
        a = rd[2*i]; b = rd[2*i+1];
        if (a != b)  begin s = a;      d = 0; end
        else if (!a) begin s = dir[i]; d = 1; end
        else         begin s = 1;      d = 1; err = 1; end
        res[4+i] = s; res[i] = d;
        wr[3*i] = 1; wr[3*i+1] = 1; wr[3*i+2] = s;
        resp[3*i] = a; resp[3*i+1] = b; resp[3*i+2] = s;
      end
    end
  endfunction

  // driver: launches one exchange and checks the slot sequence afterwards
  task automatic runX(input bit acc, input logic [7:0] dir, input logic [7:0] rd,
                      input int lat, input bit disturb, input string tag);
    logic [7:0] res; bit err; logic [15:0] wr, resp; int n, d0;
    model(acc, dir, rd, res, err, wr, resp, n);
    @(negedge clk);
    respVec = resp; respIdx = 0; wrCnt = 0; wrVec = '0; respLat = lat; waitCnt = 0;
    expQ.push_back({err, res});
    d0 = doneCnt;
    accelEn = acc; hostData = dir; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin
      repeat (3) @(negedge clk);
      accelEn = !acc;               // R10 mode flip mid-exchange
      hostData = ~dir; start = 1'b1; // R2 start while busy
      @(negedge clk);
      start = 1'b0;
    end
    while (doneCnt == d0) @(negedge clk);
    repeat (3) @(negedge clk);
    check(wrCnt == n, {tag, " slot count"}, wrCnt, n);
    check(wrVec == wr, {tag, " written slot bits"}, wrVec, wr);
    check(doneCnt == d0 + 1, {tag, " one completion"}, doneCnt, d0 + 1);
    check(!busy, {tag, " idle after"}, busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !slotReq && !doneValid && !noDevErr, "R1 reset state",
          {busy, slotReq, doneValid, noDevErr}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !slotReq, "R1 idle after reset release", {busy, slotReq}, 0);

    runX(1'b0, 8'hA5, 8'h3C, 1, 1'b0, "R4 plain transfer");
    runX(1'b0, 8'h01, 8'hFE, 0, 1'b0, "R4 plain, no stall R3");
    runX(1'b1, 8'h00, 8'b01_10_01_01, 2, 1'b0, "R5 R6 all reads differ");
    runX(1'b1, 8'h05, 8'h00, 0, 1'b0, "R7 all conflicts dir 5");
    runX(1'b1, 8'hFA, 8'h00, 3, 1'b0, "R7 high nibble ignored");
    runX(1'b1, 8'h02, 8'b00_11_10_00, 1, 1'b0, "R8 no device at bit 2");
    runX(1'b1, 8'h09, 8'b01_00_10_00, 0, 1'b0, "R6 R7 mixed");
    runX(1'b1, 8'h03, 8'b10_00_01_00, 2, 1'b1, "R2 R10 disturbed search");
    runX(1'b0, 8'h5A, 8'hC3, 2, 1'b1, "R2 R10 disturbed plain");

    check(expQ.size() == 0, "R9 all results seen", expQ.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule